// File: doc/BRIEF.md
# Extended Boundary-Scan Instruction Decoder

This block turns the instruction held in an 8-bit test instruction register into the controls of a boundary-scan test chip. It selects which data register sits between the serial data input and the serial data output: the one-bit bypass stage or a boundary register of parameterised length. It picks what that register captures on a Capture-DR strobe and sets the device mode to normal, test or high-impedance test. It also steers the core inputs and the device output pins either from the live signals or from the boundary cells' shadow latches.

The block contains the bypass bit, the boundary shift stage and its shadow latches. It takes the TAP controller's state strobes (Capture-DR, Shift-DR, Update-DR, Update-IR, Run-Test/Idle) from a controller outside the block. Next to the usual boundary, sample, bypass, high-impedance and clamp instructions, it supports three more. A read instruction leaves the boundary contents untouched on capture. A self-test instruction captures the inverse of the shadow latches. A run-test instruction enables an external test engine while the TAP is idle.

Top module: `bscan_insn_ctl`

## Requirements
- R1: The instruction register loads `ir_din` on a cycle with `upd_ir` high and resets to the bypass opcode 8'hFF. Opcodes outside the assigned set (for example 8'h5A or 8'h00) act exactly as bypass.
- R2: The opcode map is: 8'h01 external test, 8'h02 sample, 8'h03 high-Z, 8'h04 clamp, 8'h05 run-test, 8'h06 read, 8'h07 self-test, 8'hFF bypass. `sel_bsr` is 1 for 8'h01, 8'h02, 8'h06 and 8'h07 and 0 for every other value.
- R3: When bypass is selected, Capture-DR clears the bypass bit. Shift-DR moves `tdi` through that single stage to `tdo`.
- R4: Under 8'h01 and 8'h02, Capture-DR loads the boundary shift stage with {core_out, pin_in}, with the input cells in bits 0..N_IN-1 and the output cells above them. Shift-DR moves the stage toward bit 0 (`tdo`), and `tdi` enters at the top bit.
- R5: Under 8'h06, Capture-DR leaves the boundary shift stage unchanged.
- R6: Under 8'h07, Capture-DR loads every shift cell with the inverse of its shadow latch.
- R7: The shadow latches copy the shift stage on Update-DR only while a boundary-selecting instruction is in force. When Update-IR falls in the same cycle, the instruction held before that edge decides.
- R8: `dev_mode` is 0 (normal) for 8'h02, 8'h06, 8'h07, bypass and unassigned codes. It is 1 (test) for 8'h01, 8'h04 and 8'h05, and 2 (high-Z test) for 8'h03.
- R9: One cycle after each edge, in test mode, `core_in` holds the input-cell shadows and `pin_out` holds the output-cell shadows. In the other modes `core_in` holds `pin_in` and `pin_out` holds `core_out`.
- R10: `pin_oe` is 0 one cycle after an edge at which 8'h03 is in force and 1 otherwise. Under 8'h03 the core inputs keep following `pin_in`.
- R11: `run_en` is 1 one cycle after an edge at which 8'h05 is in force and `rti` is high, and 0 otherwise.
- R12: While `rst` is high, `core_in` and `pin_out` are 0, `pin_oe` is 1, `run_en` is 0, the shadows clear and `dev_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | test clock |
| rst | input | 1 | synchronous active-high reset (TAP reset) |
| upd_ir | input | 1 | Update-IR strobe, loads `ir_din` |
| ir_din | input | 8 | new instruction value |
| cap_dr | input | 1 | Capture-DR strobe |
| shf_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| rti | input | 1 | TAP is in Run-Test/Idle |
| tdi | input | 1 | serial data in |
| tdo | output | 1 | serial data out of the selected register |
| pin_in | input | N_IN | device input pin values |
| core_out | input | N_OUT | core logic outputs |
| core_in | output | N_IN | values driven to the core inputs |
| pin_out | output | N_OUT | values driven to the output pins |
| pin_oe | output | 1 | output pin enable, 0 means high impedance |
| dev_mode | output | 2 | 0 normal, 1 test, 2 high-Z test |
| sel_bsr | output | 1 | 1 when the boundary register is in the scan path |
| run_en | output | 1 | run enable to the boundary test engine |

## Verification
An instruction change and a shadow load can fall on the same edge, when Update-IR and Update-DR are high together. The shadow load must then be gated by the instruction that was in force before that edge. The bench provokes this both ways. In one case bypass is active, the shift stage holds data that differs from the shadows, and the external-test opcode is loaded in the same cycle as the update. In the other case external test is active, fresh data has been shifted in, and bypass is loaded in the same cycle as the update. The outcome is judged at the pins: once a test-mode instruction is in force, `pin_out` and `core_in` show whether the shadows took the new data.

// File: rtl/bsi_pkg.sv
package bsi_pkg;
  localparam int IR_W = 8;

  localparam logic [IR_W-1:0] OP_EXTEST = 8'h01;
  localparam logic [IR_W-1:0] OP_SAMPLE = 8'h02;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 8'h03;
  localparam logic [IR_W-1:0] OP_CLAMP  = 8'h04;
  localparam logic [IR_W-1:0] OP_RUNT   = 8'h05;
  localparam logic [IR_W-1:0] OP_READ   = 8'h06;
  localparam logic [IR_W-1:0] OP_SELF   = 8'h07;
  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_TEST = 2'd1,
    MODE_HIZ  = 2'd2
  } dev_mode_e;

  typedef enum logic [1:0] {
    CAP_ZERO = 2'd0,
    CAP_PINS = 2'd1,
    CAP_HOLD = 2'd2,
    CAP_INV  = 2'd3
  } cap_e;

  typedef struct packed {
    logic      sel_bsr;
    cap_e      cap;
    dev_mode_e mode;
    logic      oe;
    logic      run_ok;
  } ctl_t;
endpackage

// File: rtl/bsi_decode.sv
module bsi_decode
  import bsi_pkg::*;
(
  input  logic [IR_W-1:0] insn,
  output ctl_t            ctl
);
  always_comb begin
    ctl.sel_bsr = 1'b0;
    ctl.cap     = CAP_ZERO;
    ctl.mode    = MODE_NORM;
    ctl.oe      = 1'b1;
    ctl.run_ok  = 1'b0;
    case (insn)
      OP_EXTEST: begin
        ctl.sel_bsr = 1'b1;
        ctl.cap     = CAP_PINS;
        ctl.mode    = MODE_TEST;
      end
      OP_SAMPLE: begin
        ctl.sel_bsr = 1'b1;
        ctl.cap     = CAP_PINS;
      end
      OP_HIGHZ: begin
        ctl.mode = MODE_HIZ;
        ctl.oe   = 1'b0;
      end
      OP_CLAMP: ctl.mode = MODE_TEST;
      OP_RUNT: begin
        ctl.mode   = MODE_TEST;
        ctl.run_ok = 1'b1;
      end
      OP_READ: begin
        ctl.sel_bsr = 1'b1;
        ctl.cap     = CAP_HOLD;
      end
      OP_SELF: begin
        ctl.sel_bsr = 1'b1;
        ctl.cap     = CAP_INV;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bsi_bypass.sv
module bsi_bypass (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cap,
  input  logic shf,
  input  logic tdi,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)             q <= 1'b0;
    else if (en && cap)  q <= 1'b0;
    else if (en && shf)  q <= tdi;
  end
endmodule

// File: rtl/bsi_bsr.sv
module bsi_bsr
  import bsi_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  localparam int L    = N_IN + N_OUT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             cap,
  input  logic             shf,
  input  logic             upd,
  input  cap_e             cmode,
  input  logic             tdi,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [L-1:0]     sr_q,
  output logic [L-1:0]     shadow_q
);
  logic [L-1:0] par_in;
  assign par_in = {core_out, pin_in};

  for (genvar g = 0; g < L; g++) begin : g_cell
    logic nxt;
    if (g == L - 1) begin : g_top
      assign nxt = tdi;
    end else begin : g_mid
      assign nxt = sr_q[g+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        sr_q[g]     <= 1'b0;
        shadow_q[g] <= 1'b0;
      end else begin
        if (sel && cap) begin
          case (cmode)
            CAP_PINS: sr_q[g] <= par_in[g];
            CAP_INV:  sr_q[g] <= ~shadow_q[g];
            default:  ;
          endcase
        end else if (sel && shf) begin
          sr_q[g] <= nxt;
        end
        if (sel && upd) shadow_q[g] <= sr_q[g];
      end
    end
  end
endmodule

// File: rtl/bscan_insn_ctl.sv
module bscan_insn_ctl
  import bsi_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_ir,
  input  logic [7:0]       ir_din,
  input  logic             cap_dr,
  input  logic             shf_dr,
  input  logic             upd_dr,
  input  logic             rti,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pin_out,
  output logic             pin_oe,
  output logic [1:0]       dev_mode,
  output logic             sel_bsr,
  output logic             run_en
);
  localparam int L = N_IN + N_OUT;

  logic [IR_W-1:0] insn_q;
  ctl_t            ctl;
  logic [L-1:0]    sr_q;
  logic [L-1:0]    shadow_q;
  logic            byp_q;

  always_ff @(posedge clk) begin
    if (rst)         insn_q <= OP_BYPASS;
    else if (upd_ir) insn_q <= ir_din;
  end

  bsi_decode u_dec (
    .insn (insn_q),
    .ctl  (ctl)
  );

  bsi_bypass u_byp (
    .clk (clk),
    .rst (rst),
    .en  (!ctl.sel_bsr),
    .cap (cap_dr),
    .shf (shf_dr),
    .tdi (tdi),
    .q   (byp_q)
  );

  bsi_bsr #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bsr (
    .clk      (clk),
    .rst      (rst),
    .sel      (ctl.sel_bsr),
    .cap      (cap_dr),
    .shf      (shf_dr),
    .upd      (upd_dr),
    .cmode    (ctl.cap),
    .tdi      (tdi),
    .pin_in   (pin_in),
    .core_out (core_out),
    .sr_q     (sr_q),
    .shadow_q (shadow_q)
  );

  assign tdo      = ctl.sel_bsr ? sr_q[0] : byp_q;
  assign sel_bsr  = ctl.sel_bsr;
  assign dev_mode = ctl.mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_in <= '0;
      pin_out <= '0;
      pin_oe  <= 1'b1;
      run_en  <= 1'b0;
    end else begin
      if (ctl.mode == MODE_TEST) begin
        core_in <= shadow_q[N_IN-1:0];
        pin_out <= shadow_q[L-1:N_IN];
      end else begin
        core_in <= pin_in;
        pin_out <= core_out;
      end
      pin_oe <= ctl.oe;
      run_en <= ctl.run_ok & rti;
    end
  end
endmodule

// File: rtl/bsi_chk.sv
module bsi_chk
  import bsi_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  localparam int L    = N_IN + N_OUT
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_ir,
  input logic             cap_dr,
  input logic             shf_dr,
  input logic             upd_dr,
  input logic             rti,
  input logic             tdo,
  input logic             sel_bsr,
  input cap_e             cmode,
  input logic [1:0]       dev_mode,
  input logic             pin_oe,
  input logic             run_en,
  input logic [L-1:0]     sr,
  input logic [L-1:0]     shadow,
  input logic [N_IN-1:0]  pin_in,
  input logic [N_OUT-1:0] core_out,
  input logic [N_IN-1:0]  core_in,
  input logic [N_OUT-1:0] pin_out
);
  // R3
  bypass_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_dr && !sel_bsr && !upd_ir) |=> !tdo);

  // R5
  hold_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_dr && sel_bsr && cmode == CAP_HOLD && !shf_dr) |=> $stable(sr));

  // R6
  invert_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_dr && sel_bsr && cmode == CAP_INV && !shf_dr) |=> (sr == ~$past(shadow)));

  // R7
  shadow_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(upd_dr && sel_bsr) |=> $stable(shadow));

  // R11
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    run_en |-> $past(rti));

  // R9
  normal_path_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dev_mode) == MODE_NORM)
      |-> (pin_out == $past(core_out) && core_in == $past(pin_in)));

  // R10
  hiz_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dev_mode) == MODE_HIZ) |-> !pin_oe);
endmodule

bind bscan_insn_ctl bsi_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .upd_ir   (upd_ir),
  .cap_dr   (cap_dr),
  .shf_dr   (shf_dr),
  .upd_dr   (upd_dr),
  .rti      (rti),
  .tdo      (tdo),
  .sel_bsr  (sel_bsr),
  .cmode    (ctl.cap),
  .dev_mode (dev_mode),
  .pin_oe   (pin_oe),
  .run_en   (run_en),
  .sr       (sr_q),
  .shadow   (shadow_q),
  .pin_in   (pin_in),
  .core_out (core_out),
  .core_in  (core_in),
  .pin_out  (pin_out)
);

// File: tb/sim_bscan_insn_ctl.sv
`timescale 1ns/1ps
module sim_bscan_insn_ctl;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int L  = NI + NO;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          upd_ir = 1'b0, cap_dr = 1'b0, shf_dr = 1'b0, upd_dr = 1'b0;
  logic          rti = 1'b0, tdi = 1'b0;
  logic [7:0]    ir_din = 8'hFF;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0;
  logic          tdo, pin_oe, sel_bsr, run_en;
  logic [NI-1:0] core_in;
  logic [NO-1:0] pin_out;
  logic [1:0]    dev_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bscan_insn_ctl #(.N_IN(NI), .N_OUT(NO)) u0 (
    .clk(clk), .rst(rst), .upd_ir(upd_ir), .ir_din(ir_din),
    .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr), .rti(rti),
    .tdi(tdi), .tdo(tdo), .pin_in(pin_in), .core_out(core_out),
    .core_in(core_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .dev_mode(dev_mode), .sel_bsr(sel_bsr), .run_en(run_en)
  );

  // fields: op[13:6] sel[5] mode[4:3] oe[2] cap[1:0] (0 zero,1 pins,2 hold,3 inv)
  localparam logic [13:0] VEC [9] = '{
    {8'h01, 1'b1, 2'd1, 1'b1, 2'd1},
    {8'h02, 1'b1, 2'd0, 1'b1, 2'd1},
    {8'h03, 1'b0, 2'd2, 1'b0, 2'd0},
    {8'h04, 1'b0, 2'd1, 1'b1, 2'd0},
    {8'h05, 1'b0, 2'd1, 1'b1, 2'd0},
    {8'h06, 1'b1, 2'd0, 1'b1, 2'd2},
    {8'h07, 1'b1, 2'd0, 1'b1, 2'd3},
    {8'hFF, 1'b0, 2'd0, 1'b1, 2'd0},
    {8'h5A, 1'b0, 2'd0, 1'b1, 2'd0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_ir(input logic [7:0] op);
    ir_din = op; upd_ir = 1'b1; tick(); upd_ir = 1'b0;
  endtask

  task automatic do_cap();
    cap_dr = 1'b1; tick(); cap_dr = 1'b0;
  endtask

  task automatic do_upd();
    upd_dr = 1'b1; tick(); upd_dr = 1'b0;
  endtask

  task automatic shift(input logic [L-1:0] q, output logic [L-1:0] rd);
    for (int i = 0; i < L; i++) begin
      rd[i] = tdo;
      tdi = q[i]; shf_dr = 1'b1; tick();
    end
    shf_dr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [L-1:0] rd, p, q, sh, expc;
    logic [NI-1:0] a;
    logic [NO-1:0] b;
    @(negedge clk);
    pin_in = 4'h9; core_out = 4'h6;
    tick(); tick();
    // R12 reset state
    chk("R12 core_in", core_in, 0);
    chk("R12 pin_out", pin_out, 0);
    chk("R12 pin_oe", pin_oe, 1);
    chk("R12 run_en", run_en, 0);
    chk("R12 dev_mode", dev_mode, 0);
    rst = 1'b0;
    tick();
    // R1 instruction comes out of reset as bypass
    chk("R1 sel_bsr after reset", sel_bsr, 0);
    chk("R9 normal path after reset", {core_in, pin_out}, {4'h9, 4'h6});

    foreach (VEC[k]) begin
      logic [7:0] op;
      logic       esel, eoe;
      logic [1:0] emode, ecap;
      {op, esel, emode, eoe, ecap} = VEC[k];
      p = 8'hA5 ^ L'(k);
      q = 8'h96 ^ L'(k * 17);
      a = 4'h3 ^ NI'(k);
      b = 4'hC ^ NO'(k);
      load_ir(8'h02);
      shift(p, rd);
      do_upd();
      load_ir(op);
      pin_in = a; core_out = b;
      // R2 R8 R1
      chk($sformatf("R2 sel_bsr op %0h", op), sel_bsr, esel);
      chk($sformatf("R8 dev_mode op %0h", op), dev_mode, emode);
      do_cap();
      shift(q, rd);
      if (esel) begin
        case (ecap)
          2'd1:    expc = {b, a};
          2'd2:    expc = p;
          default: expc = ~p;
        endcase
        chk($sformatf("R4 R5 R6 captured op %0h", op), rd, expc);
      end else begin
        chk($sformatf("R3 bypass capture op %0h", op), rd[0], 0);
        chk($sformatf("R3 bypass stage op %0h", op), rd[1], q[0]);
      end
      do_upd();
      tick();
      sh = esel ? q : p;
      chk($sformatf("R7 R9 core_in op %0h", op), core_in, (emode == 2'd1) ? sh[NI-1:0] : a);
      chk($sformatf("R7 R9 pin_out op %0h", op), pin_out, (emode == 2'd1) ? sh[L-1:NI] : b);
      chk($sformatf("R10 pin_oe op %0h", op), pin_oe, eoe);
    end

    // R11 run enable only with run-test and idle
    load_ir(8'h05);
    rti = 1'b1; tick();
    chk("R11 run_en runtest idle", run_en, 1);
    rti = 1'b0; tick();
    chk("R11 run_en runtest not idle", run_en, 0);
    load_ir(8'h01);
    rti = 1'b1; tick();
    chk("R11 run_en other insn", run_en, 0);
    rti = 1'b0;
    load_ir(8'h00);
    chk("R1 unassigned 00 sel", sel_bsr, 0);
    chk("R1 unassigned 00 mode", dev_mode, 0);

    // R7 instruction change and update on the same edge
    load_ir(8'h02);
    shift(8'h3C, rd);
    do_upd();
    shift(8'hE1, rd);
    load_ir(8'hFF);
    ir_din = 8'h01; upd_ir = 1'b1; upd_dr = 1'b1; tick();
    upd_ir = 1'b0; upd_dr = 1'b0;
    tick();
    chk("R7 coincident from bypass pin_out", pin_out, 4'h3);
    chk("R7 coincident from bypass core_in", core_in, 4'hC);
    do_upd(); tick();
    chk("R7 later update pin_out", pin_out, 4'hE);
    chk("R7 later update core_in", core_in, 4'h1);
    shift(8'h77, rd);
    ir_din = 8'hFF; upd_ir = 1'b1; upd_dr = 1'b1; tick();
    upd_ir = 1'b0; upd_dr = 1'b0;
    load_ir(8'h04);
    tick();
    chk("R7 coincident from extest pin_out", pin_out, 4'h7);
    chk("R7 coincident from extest core_in", core_in, 4'h7);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule